// File: doc/BRIEF.md
# Serial DAC Input Register with Load Control

This block is the digital front end of a serial-input digital-to-analog converter. A host sends a word over three wires: a serial clock, a data line and an active-low frame sync. While the frame sync is low, the block shifts one bit in on each falling edge of the serial clock, most significant bit first. A word is 16 bits long. The upper four bits carry no meaning. The lower twelve bits, whose least significant bit is the last one shifted in, form the converter code.

The code reaches the DAC latch in one of two ways. If the load input is held low, the latch takes the code on the 16th falling edge of the frame. If the load input is high, a completed word waits in a holding register. It moves into the latch on the next falling edge of the load input.

The three serial pins and the load pin are asynchronous to the block. They pass through two-flop synchronizers into the system clock domain, and all edges are detected there. Each serial clock phase must last several system clock cycles.

A frame state machine has three states:
- **IDLE**: no frame is in progress.
- **SHIFT**: a frame is open and bits are being counted.
- **FULL**: 16 bits have arrived and further edges are ignored.

Its transitions are:
- IDLE to SHIFT when the frame sync is seen low.
- SHIFT to FULL on the 16th counted falling edge.
- SHIFT to IDLE when the frame sync rises early, which is an abort.
- FULL to IDLE when the frame sync rises.

Top module: `dac_front_end`

## Requirements
- R1: After reset, `dac_code` and `shift_view` are both zero.
- R2: While `frame_n` is low and fewer than 16 bits have been taken, each falling edge of `sclk_pin` shifts `sdata` into bit 0 of `shift_view`, and the older bits move one place toward bit 15. After a full frame, `shift_view` equals the sent word, whose first-sent bit is bit 15.
- R3: When `load_n` is low at the 16th falling edge of a frame, `dac_code` becomes bits [11:0] of the word. Bits [15:12] have no effect on it.
- R4: `dac_code` does not change after 15 falling edges of a frame. It changes only on the 16th edge or on a load strobe.
- R5: When `load_n` is high at the end of a frame, `dac_code` keeps its value. The next falling edge of `load_n` copies bits [11:0] of the most recently completed word into `dac_code`.
- R6: A falling edge of `load_n` during an unfinished frame loads the previously completed word, not the partial one.
- R7: A pause of any length in `sclk_pin` while `frame_n` stays low does not reset the bit count. Two 8-edge bursts make one word.
- R8: If `frame_n` rises after fewer than 16 edges, the partial word is dropped. `shift_view` clears to zero, `dac_code` and the held word do not change, and the next frame counts from zero.
- R9: Falling edges after the 16th in the same frame change neither `shift_view` nor `dac_code`. The bit count never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_pin | input | 1 | Serial clock; data is taken on its falling edge |
| frame_n | input | 1 | Active-low frame sync |
| sdata | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Load control: held low selects automatic update; a falling edge is a deferred load strobe |
| dac_code | output | 12 | DAC latch contents |
| shift_view | output | 16 | Debug view of the input shift register |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 12-bit code and two synchronizer stages. At this size every bit position can be checked directly. The automatic-mode sweep sends about forty words, including all-ones, all-zeros and codes with only the don't-care bits set. For each word it checks the partial register after 15 edges and the latch after the 16th, with expected values computed by shifts and masks. Shorter scenarios cover the rest: aborts at edge 10, surplus edges, an 8+8 gapped burst, and load strobes both between frames and in the middle of a frame.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2
    } frame_st_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fall_detect.sv
module fall_detect #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= level;
    end

    assign fall = prev & ~level;
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
    import dacfe_pkg::*;
#(
    parameter int WORD_BITS = 16,
    parameter int CNT_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fs_low,
    input  logic                 sck_fall,
    input  logic                 din,
    output logic [CNT_W-1:0]     bit_cnt,
    output logic [WORD_BITS-1:0] shreg,
    output logic                 word_done,
    output logic [WORD_BITS-1:0] new_word
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

    frame_st_e state, nxt;
    logic      take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (fs_low) nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (!fs_low)        nxt = ST_IDLE;
                else if (word_done) nxt = ST_FULL;
            end
            ST_FULL:  if (!fs_low) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        take      = fs_low && (state != ST_FULL) && sck_fall;
        new_word  = {shreg[WORD_BITS-2:0], din};
        word_done = take && (bit_cnt == LAST);
    end

    // bit counter and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (!fs_low) begin
            bit_cnt <= '0;
            if (state == ST_SHIFT) shreg <= '0;
        end else if (take) begin
            shreg   <= new_word;
            bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/code_latch.sv
module code_latch #(
    parameter int CODE_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_done,
    input  logic [CODE_BITS-1:0] code_in,
    input  logic                 load_low,
    input  logic                 load_fall,
    output logic [CODE_BITS-1:0] dac_code
);
    logic [CODE_BITS-1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held     <= '0;
            dac_code <= '0;
        end else begin
            if (word_done) held <= code_in;
            if (word_done && load_low) dac_code <= code_in;
            else if (load_fall)        dac_code <= held;
        end
    end
endmodule

// File: rtl/dac_front_end.sv
module dac_front_end #(
    parameter int WORD_BITS = 16,
    parameter int CODE_BITS = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_pin,
    input  logic                 frame_n,
    input  logic                 sdata,
    input  logic                 load_n,
    output logic [CODE_BITS-1:0] dac_code,
    output logic [WORD_BITS-1:0] shift_view
);
    localparam int CNT_W = $clog2(WORD_BITS + 1);

    logic [3:0]           pins_s;
    logic [1:0]           falls;
    logic                 sck_fall, load_fall, fs_low, load_low, din;
    logic                 word_done;
    logic [CNT_W-1:0]     bit_cnt;
    logic [WORD_BITS-1:0] new_word;

    pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d ({load_n, frame_n, sclk_pin, sdata}),
        .q (pins_s)
    );

    fall_detect #(.W(2)) u_fall (
        .clk (clk),
        .rst_n (rst_n),
        .level ({pins_s[3], pins_s[1]}),
        .fall (falls)
    );

    assign sck_fall  = falls[0];
    assign load_fall = falls[1];
    assign fs_low    = ~pins_s[2];
    assign load_low  = ~pins_s[3];
    assign din       = pins_s[0];

    frame_ctrl #(.WORD_BITS(WORD_BITS), .CNT_W(CNT_W)) u_frame (
        .clk (clk),
        .rst_n (rst_n),
        .fs_low (fs_low),
        .sck_fall (sck_fall),
        .din (din),
        .bit_cnt (bit_cnt),
        .shreg (shift_view),
        .word_done (word_done),
        .new_word (new_word)
    );

    code_latch #(.CODE_BITS(CODE_BITS)) u_latch (
        .clk (clk),
        .rst_n (rst_n),
        .word_done (word_done),
        .code_in (new_word[CODE_BITS-1:0]),
        .load_low (load_low),
        .load_fall (load_fall),
        .dac_code (dac_code)
    );
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
    parameter int WORD_BITS = 16,
    parameter int CODE_BITS = 12,
    parameter int CNT_W = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fs_low,
    input logic                 load_low,
    input logic                 load_fall,
    input logic                 word_done,
    input logic [CNT_W-1:0]     bit_cnt,
    input logic [CODE_BITS-1:0] code_in,
    input logic [CODE_BITS-1:0] dac_code,
    input logic [WORD_BITS-1:0] shift_view
);
    // R4
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_done && !load_fall) |=> $stable(dac_code));

    // R3
    auto_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && load_low) |=> (dac_code == $past(code_in)));

    // R5
    defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !load_low && !load_fall) |=> $stable(dac_code));

    // R8
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_low |=> (bit_cnt == '0));

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(WORD_BITS));

    // R9
    full_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == CNT_W'(WORD_BITS) && fs_low) |=> $stable(shift_view));
endmodule

bind dac_front_end dacfe_chk #(
    .WORD_BITS(WORD_BITS), .CODE_BITS(CODE_BITS), .CNT_W(CNT_W)
) u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .fs_low (fs_low),
    .load_low (load_low),
    .load_fall (load_fall),
    .word_done (word_done),
    .bit_cnt (bit_cnt),
    .code_in (new_word[CODE_BITS-1:0]),
    .dac_code (dac_code),
    .shift_view (shift_view)
);

// File: tb/sim_dac_front_end.sv
`timescale 1ns/1ps
module sim_dac_front_end;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_pin = 1'b1;
    logic        frame_n = 1'b1;
    logic        sdata = 1'b0;
    logic        load_n = 1'b0;
    logic [11:0] dac_code;
    logic [15:0] shift_view;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dac_front_end u0 (
        .clk (clk), .rst_n (rst_n), .sclk_pin (sclk_pin), .frame_n (frame_n),
        .sdata (sdata), .load_n (load_n), .dac_code (dac_code), .shift_view (shift_view)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        @(negedge clk);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [15:0] w, input int first, input int cnt);
        for (int k = first; k < first + cnt; k++) begin
            sdata = w[15-k];
            waitc(3);
            sclk_pin = 1'b0;
            waitc(4);
            sclk_pin = 1'b1;
            waitc(3);
        end
        waitc(4);
    endtask

    task automatic fbegin();
        frame_n = 1'b0;
        waitc(5);
    endtask

    task automatic fend();
        waitc(2);
        frame_n = 1'b1;
        waitc(8);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        waitc(6);
        load_n = 1'b1;
        waitc(8);
    endtask

    initial begin
        logic [15:0] w, prev_view, w2;
        logic [11:0] exp_code;

        waitc(3);
        rst_n = 1'b1;
        waitc(6);
        check("R1 dac_code", {4'h0, dac_code}, 16'h0000);
        check("R1 shift_view", shift_view, 16'h0000);

        exp_code = 12'h000;
        prev_view = 16'h0000;
        for (int i = 0; i < 40; i++) begin
            if (i == 0)      w = 16'hFFFF;
            else if (i == 1) w = 16'h0000;
            else if (i == 2) w = 16'hF000;
            else if (i == 3) w = 16'h0FFF;
            else             w = 16'((i * 40503 + 7) ^ (i << 9));
            fbegin();
            send_bits(w, 0, 15);
            check("R4 no update after 15 edges", {4'h0, dac_code}, {4'h0, exp_code});
            check("R2 partial shift", shift_view, 16'((prev_view << 15) | (w >> 1)));
            send_bits(w, 15, 1);
            exp_code = w[11:0];
            check("R3 auto update", {4'h0, dac_code}, {4'h0, exp_code});
            check("R2 full word", shift_view, w);
            fend();
            prev_view = w;
        end

        // R9: surplus edges ignored
        w = 16'h5A3C;
        fbegin();
        send_bits(w, 0, 16);
        exp_code = w[11:0];
        send_bits(~w, 0, 5);
        check("R9 view after extra edges", shift_view, w);
        check("R9 code after extra edges", {4'h0, dac_code}, {4'h0, exp_code});
        fend();

        // R7: gapped bursts
        w = 16'h9C81;
        fbegin();
        send_bits(w, 0, 8);
        waitc(200);
        check("R7 no update mid gap", {4'h0, dac_code}, {4'h0, exp_code});
        send_bits(w, 8, 8);
        exp_code = w[11:0];
        check("R7 update after second burst", {4'h0, dac_code}, {4'h0, exp_code});
        fend();

        // R8: abort then fresh frame
        w = 16'hFFFF;
        fbegin();
        send_bits(w, 0, 10);
        fend();
        check("R8 view cleared", shift_view, 16'h0000);
        check("R8 code kept", {4'h0, dac_code}, {4'h0, exp_code});
        w = 16'h1234;
        fbegin();
        send_bits(w, 0, 6);
        check("R8 count restarted", {4'h0, dac_code}, {4'h0, exp_code});
        send_bits(w, 6, 10);
        exp_code = w[11:0];
        check("R8 full frame after abort", {4'h0, dac_code}, {4'h0, exp_code});
        fend();

        // R5: deferred loads
        load_n = 1'b1;
        waitc(8);
        for (int i = 0; i < 8; i++) begin
            w = 16'((i * 12345 + 4321) ^ 16'hA5A5);
            fbegin();
            send_bits(w, 0, 16);
            fend();
            check("R5 held without strobe", {4'h0, dac_code}, {4'h0, exp_code});
            pulse_load();
            exp_code = w[11:0];
            check("R5 strobe loads word", {4'h0, dac_code}, {4'h0, exp_code});
        end

        // R6: strobe during a partial frame
        w = 16'h3BEE;
        fbegin();
        send_bits(w, 0, 16);
        fend();
        w2 = 16'hC0DE;
        fbegin();
        send_bits(w2, 0, 8);
        pulse_load();
        check("R6 strobe mid frame uses previous", {4'h0, dac_code}, {4'h0, w[11:0]});
        send_bits(w2, 8, 8);
        check("R5 no auto update with load high", {4'h0, dac_code}, {4'h0, w[11:0]});
        fend();
        pulse_load();
        check("R6 strobe after completion", {4'h0, dac_code}, {4'h0, w2[11:0]});

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule